// File: doc/BRIEF.md
# Multi-accumulator multiply-accumulate unit

This block is the arithmetic core of a multiply-accumulate engine with four 48-bit accumulators. Each accepted operation multiplies two operands, either full 32-bit values or one 16-bit half chosen from each, and adds the product to a chosen accumulator or subtracts it. The result goes back into that accumulator, and the negative, zero and overflow flags are updated. A status register holds two mode bits that decide how operands are read: as unsigned integers, as two's-complement integers, or as two's-complement fractions in which the all-ones-below-sign pattern is the largest value and the sign-only pattern stands for -1.

Overflow is remembered for each accumulator separately. A sticky bit per accumulator records any product or accumulation overflow since that accumulator, or the status register, was last written. The overflow flag reported after an operation is the sticky bit of the accumulator that operation targeted. A separate write port loads an accumulator directly, and a combinational read port returns any accumulator together with its sticky bit.

Top module: `macc_quad`

## Requirements
- R1: After synchronous reset, all accumulators read 0, all sticky bits and the N, Z and V flags are 0, `res_valid` is 0, and the mode is signed integer (`stat_signed`=1, `stat_frac`=0).
- R2: Operand format: if the fractional mode bit is 1 the format is signed fractional, whatever the signed bit says. Otherwise the signed bit selects signed integer (1) or unsigned integer (0). Signed and fractional operands are sign-extended and unsigned operands are zero-extended.
- R3: With `op_word`=1 each operand is one 16-bit half of its input. `op_a_hi`/`op_b_hi`=1 takes bits 31:16 and 0 takes bits 15:0. With `op_word`=0 all 32 bits are used.
- R4: In fractional format the exact product is doubled. For 32-bit fractional operands the doubled product is then shifted right arithmetically by 16, so that 0x8000_0000 × 0x8000_0000 gives +2^47.
- R5: `op_sub`=1 computes accumulator minus product term, and 0 computes accumulator plus product term. The accumulator is extended to full precision, signed in signed/fractional modes and unsigned in unsigned mode, and the accumulator receives bits 47:0 of the exact result.
- R6: The target is `op_acc` when `op_named`=1 and accumulator 0 when `op_named`=0. The other accumulators and their sticky bits are unchanged.
- R7: After an accepted operation, N equals bit 47 of the new accumulator and Z is 1 exactly when the new accumulator is zero.
- R8: A product overflow occurs only for 32-bit integer operations: in signed mode when the exact product lies outside [-2^39, 2^39-1], and in unsigned mode when it is 2^40 or more.
- R9: An accumulation overflow occurs when the exact result lies outside [-2^47, 2^47-1] in signed or fractional mode, or outside [0, 2^48-1] in unsigned mode.
- R10: The target's sticky bit becomes its old value OR product overflow OR accumulation overflow. V after the operation equals that new sticky bit, and a sticky bit never falls except by R11 or reset.
- R11: `acc_wr` loads `acc_wdata` into accumulator `acc_wsel` and clears its sticky bit. `sr_wr` loads both mode bits and clears every sticky bit and the N, Z and V flags.
- R12: An `op_valid` in the same cycle as `acc_wr` or `sr_wr` is dropped. It produces no `res_valid` and makes no change to any accumulator or flag.
- R13: `res_valid` is high for exactly the one cycle after each accepted operation, and the new accumulator value and flags are visible in that cycle. `acc_rdata`/`acc_rovf` follow `acc_rsel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_sub | input | 1 | 1 subtracts the product, 0 adds it |
| op_named | input | 1 | 1 uses `op_acc` as target, 0 targets accumulator 0 |
| op_acc | input | 2 | Target accumulator index |
| op_word | input | 1 | 1 selects 16-bit half operands |
| op_a_hi | input | 1 | Half select for operand A (1 = upper) |
| op_b_hi | input | 1 | Half select for operand B (1 = upper) |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| sr_wr | input | 1 | Status register write strobe |
| sr_signed | input | 1 | Signed mode bit to write |
| sr_frac | input | 1 | Fractional mode bit to write |
| acc_wr | input | 1 | Accumulator write strobe |
| acc_wsel | input | 2 | Accumulator write index |
| acc_wdata | input | 48 | Accumulator write data |
| acc_rsel | input | 2 | Accumulator read index |
| acc_rdata | output | 48 | Selected accumulator value |
| acc_rovf | output | 1 | Sticky overflow bit of selected accumulator |
| stat_signed | output | 1 | Current signed mode bit |
| stat_frac | output | 1 | Current fractional mode bit |
| res_valid | output | 1 | One-cycle strobe after an accepted operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
A wrong accumulator or sticky bit shows on the read port in the cycle right after the operation that wrote it. Because the bench reads back all four accumulators after every operation, damage to a target that was not selected is seen at once and does not wait until that accumulator is used again. A sticky bit that is lost or set wrongly shows in `flag_v` on the next operation to that accumulator, and on `acc_rovf` straight away. A wrong mode decode or half select corrupts the accumulator value in the same cycle. The sweep covers the boundary patterns (zero, ±1, the most negative value, the most positive value) under all three formats, both operand sizes, and both add and subtract.

// File: rtl/macc_pkg.sv
`timescale 1ns/1ps
package macc_pkg;

    localparam int OP_W_DEF   = 32;
    localparam int ACC_W_DEF  = 48;
    localparam int N_ACC_DEF  = 4;
    localparam int PLIM_W_DEF = 40;

    typedef enum logic [1:0] {
        FMT_UINT  = 2'd0,
        FMT_SINT  = 2'd1,
        FMT_SFRAC = 2'd2
    } fmt_e;

    typedef struct packed {
        logic is_signed;
        logic is_frac;
    } mode_t;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
    } flags_t;

    // Fractional bit dominates; signed bit decides between the integer formats.
    function automatic fmt_e fmt_of(mode_t m);
        fmt_e f;
        if (m.is_frac)        f = FMT_SFRAC;
        else if (m.is_signed) f = FMT_SINT;
        else                  f = FMT_UINT;
        return f;
    endfunction

    function automatic logic fmt_is_signed(fmt_e f);
        return f != FMT_UINT;
    endfunction

endpackage

// File: rtl/macc_opsel.sv
`timescale 1ns/1ps
module macc_opsel #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   raw,
    input  logic              word,
    input  logic              upper,
    input  logic              sgn,
    output logic signed [OP_W:0] ext
);
    localparam int HALF_W = OP_W / 2;

    logic [HALF_W-1:0] half;

    always_comb begin
        half = upper ? raw[OP_W-1:HALF_W] : raw[HALF_W-1:0];
        if (word) begin
            ext = {{(OP_W + 1 - HALF_W){sgn & half[HALF_W-1]}}, half};
        end else begin
            ext = {sgn & raw[OP_W-1], raw};
        end
    end
endmodule

// File: rtl/macc_mul.sv
`timescale 1ns/1ps
module macc_mul
    import macc_pkg::*;
#(
    parameter int OP_W   = 32,
    parameter int PLIM_W = 40,
    parameter int WIDE   = 2 * OP_W + 4
) (
    input  logic signed [OP_W:0]   a,
    input  logic signed [OP_W:0]   b,
    input  fmt_e                   fmt,
    input  logic                   word,
    output logic signed [WIDE-1:0] term,
    output logic                   prod_ovf
);
    localparam int HALF_W = OP_W / 2;
    localparam int PW     = 2 * OP_W + 2;

    logic signed [PW-1:0]   prod;
    logic signed [WIDE-1:0] prod_x;
    logic signed [WIDE-1:0] dbl;

    always_comb begin
        prod   = PW'(a) * PW'(b);
        prod_x = WIDE'(prod);
        dbl    = prod_x <<< 1;
        term   = prod_x;
        if (fmt == FMT_SFRAC) begin
            // align the binary point; long fractions keep the upper part
            term = word ? dbl : (dbl >>> HALF_W);
        end
        prod_ovf = 1'b0;
        if (!word && fmt != FMT_SFRAC) begin
            if (fmt == FMT_SINT) begin
                prod_ovf = !((&prod_x[WIDE-1:PLIM_W-1]) || !(|prod_x[WIDE-1:PLIM_W-1]));
            end else begin
                prod_ovf = |prod_x[WIDE-1:PLIM_W];
            end
        end
    end
endmodule

// File: rtl/macc_combine.sv
`timescale 1ns/1ps
module macc_combine
    import macc_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int WIDE  = 68
) (
    input  logic [ACC_W-1:0]       acc_old,
    input  logic                   sticky_old,
    input  logic signed [WIDE-1:0] term,
    input  logic                   sub,
    input  fmt_e                   fmt,
    input  logic                   prod_ovf,
    output logic [ACC_W-1:0]       acc_new,
    output flags_t                 flags,
    output logic                   sticky_new
);
    logic signed [WIDE-1:0] acc_x;
    logic signed [WIDE-1:0] total;
    logic                   acc_ovf;
    logic                   sgn;

    always_comb begin
        sgn   = fmt_is_signed(fmt);
        acc_x = {{(WIDE - ACC_W){sgn & acc_old[ACC_W-1]}}, acc_old};
        total = sub ? (acc_x - term) : (acc_x + term);
        if (sgn) begin
            acc_ovf = !((&total[WIDE-1:ACC_W-1]) || !(|total[WIDE-1:ACC_W-1]));
        end else begin
            acc_ovf = |total[WIDE-1:ACC_W];
        end
        acc_new    = total[ACC_W-1:0];
        sticky_new = sticky_old | prod_ovf | acc_ovf;
        flags.neg  = acc_new[ACC_W-1];
        flags.zero = (acc_new == '0);
        flags.ovf  = sticky_new;
    end
endmodule

// File: rtl/macc_bank.sv
`timescale 1ns/1ps
module macc_bank #(
    parameter int N_ACC = 4,
    parameter int ACC_W = 48,
    parameter int IDX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd_en,
    input  logic [IDX_W-1:0]       upd_idx,
    input  logic [ACC_W-1:0]       upd_acc,
    input  logic                   upd_sticky,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [ACC_W-1:0]       wr_data,
    input  logic                   clr_sticky,
    output logic [N_ACC*ACC_W-1:0] acc_all,
    output logic [N_ACC-1:0]       sticky_all
);
    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        logic [ACC_W-1:0] acc_q;
        logic             sticky_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q    <= '0;
                sticky_q <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    acc_q    <= wr_data;
                    sticky_q <= 1'b0;
                end else if (upd_en && upd_idx == IDX_W'(g)) begin
                    acc_q    <= upd_acc;
                    sticky_q <= upd_sticky;
                end
                if (clr_sticky) begin
                    sticky_q <= 1'b0;
                end
            end
        end

        assign acc_all[g*ACC_W +: ACC_W] = acc_q;
        assign sticky_all[g]             = sticky_q;
    end
endmodule

// File: rtl/macc_quad.sv
`timescale 1ns/1ps
module macc_quad
    import macc_pkg::*;
#(
    parameter int OP_W   = OP_W_DEF,
    parameter int ACC_W  = ACC_W_DEF,
    parameter int N_ACC  = N_ACC_DEF,
    parameter int PLIM_W = PLIM_W_DEF,
    localparam int IDX_W = $clog2(N_ACC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic             op_named,
    input  logic [IDX_W-1:0] op_acc,
    input  logic             op_word,
    input  logic             op_a_hi,
    input  logic             op_b_hi,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             sr_wr,
    input  logic             sr_signed,
    input  logic             sr_frac,
    input  logic             acc_wr,
    input  logic [IDX_W-1:0] acc_wsel,
    input  logic [ACC_W-1:0] acc_wdata,
    input  logic [IDX_W-1:0] acc_rsel,
    output logic [ACC_W-1:0] acc_rdata,
    output logic             acc_rovf,
    output logic             stat_signed,
    output logic             stat_frac,
    output logic             res_valid,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v
);
    localparam int WIDE = 2 * OP_W + 4;

    mode_t  mode_q;
    fmt_e   fmt;
    flags_t flags_q;
    flags_t flags_nx;
    logic   res_valid_q;

    logic             accept;
    logic [IDX_W-1:0] tgt;

    logic [OP_W-1:0]      raw_v   [2];
    logic                 upper_v [2];
    logic signed [OP_W:0] ext_v   [2];

    logic signed [WIDE-1:0] term;
    logic                   prod_ovf;

    logic [N_ACC*ACC_W-1:0] acc_all;
    logic [N_ACC-1:0]       sticky_all;
    logic [ACC_W-1:0]       acc_old;
    logic [ACC_W-1:0]       acc_new;
    logic                   sticky_new;

    assign fmt    = fmt_of(mode_q);
    assign accept = op_valid && !acc_wr && !sr_wr;
    assign tgt    = op_named ? op_acc : '0;

    assign raw_v[0]   = op_a;
    assign raw_v[1]   = op_b;
    assign upper_v[0] = op_a_hi;
    assign upper_v[1] = op_b_hi;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        macc_opsel #(.OP_W(OP_W)) u_sel (
            .raw   (raw_v[k]),
            .word  (op_word),
            .upper (upper_v[k]),
            .sgn   (fmt_is_signed(fmt)),
            .ext   (ext_v[k])
        );
    end

    macc_mul #(.OP_W(OP_W), .PLIM_W(PLIM_W), .WIDE(WIDE)) u_mul (
        .a        (ext_v[0]),
        .b        (ext_v[1]),
        .fmt      (fmt),
        .word     (op_word),
        .term     (term),
        .prod_ovf (prod_ovf)
    );

    assign acc_old = acc_all[tgt*ACC_W +: ACC_W];

    macc_combine #(.ACC_W(ACC_W), .WIDE(WIDE)) u_comb (
        .acc_old    (acc_old),
        .sticky_old (sticky_all[tgt]),
        .term       (term),
        .sub        (op_sub),
        .fmt        (fmt),
        .prod_ovf   (prod_ovf),
        .acc_new    (acc_new),
        .flags      (flags_nx),
        .sticky_new (sticky_new)
    );

    macc_bank #(.N_ACC(N_ACC), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .upd_en     (accept),
        .upd_idx    (tgt),
        .upd_acc    (acc_new),
        .upd_sticky (sticky_new),
        .wr_en      (acc_wr),
        .wr_idx     (acc_wsel),
        .wr_data    (acc_wdata),
        .clr_sticky (sr_wr),
        .acc_all    (acc_all),
        .sticky_all (sticky_all)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '{is_signed: 1'b1, is_frac: 1'b0};
            flags_q     <= '0;
            res_valid_q <= 1'b0;
        end else begin
            res_valid_q <= accept;
            if (sr_wr) begin
                mode_q  <= '{is_signed: sr_signed, is_frac: sr_frac};
                flags_q <= '0;
            end else if (accept) begin
                flags_q <= flags_nx;
            end
        end
    end

    assign acc_rdata   = acc_all[acc_rsel*ACC_W +: ACC_W];
    assign acc_rovf    = sticky_all[acc_rsel];
    assign stat_signed = mode_q.is_signed;
    assign stat_frac   = mode_q.is_frac;
    assign res_valid   = res_valid_q;
    assign flag_n      = flags_q.neg;
    assign flag_z      = flags_q.zero;
    assign flag_v      = flags_q.ovf;
endmodule

// File: rtl/macc_quad_chk.sv
`timescale 1ns/1ps
module macc_quad_chk #(
    parameter int ACC_W = 48,
    parameter int N_ACC = 4,
    parameter int IDX_W = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   op_valid,
    input logic                   op_named,
    input logic [IDX_W-1:0]       op_acc,
    input logic                   sr_wr,
    input logic                   acc_wr,
    input logic [IDX_W-1:0]       acc_wsel,
    input logic [ACC_W-1:0]       acc_wdata,
    input logic [N_ACC*ACC_W-1:0] acc_all,
    input logic [N_ACC-1:0]       sticky_all,
    input logic                   res_valid,
    input logic                   flag_n,
    input logic                   flag_z,
    input logic                   flag_v
);
    logic             acc_ok;
    logic [IDX_W-1:0] tgt_q;
    logic [IDX_W-1:0] wsel_q;

    assign acc_ok = op_valid && !acc_wr && !sr_wr;

    always_ff @(posedge clk) begin
        tgt_q  <= op_named ? op_acc : '0;
        wsel_q <= acc_wsel;
    end

    // R13: strobe follows an accepted operation by one cycle
    a_r13_valid_after_op: assert property (@(posedge clk) disable iff (rst)
        acc_ok |=> res_valid);

    // R12 R13: no strobe without an accepted operation
    a_r12_no_valid_when_dropped: assert property (@(posedge clk) disable iff (rst)
        !acc_ok |=> !res_valid);

    // R10: sticky bits only rise unless a write clears them
    a_r10_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        (!acc_wr && !sr_wr) |=> ((sticky_all & $past(sticky_all)) == $past(sticky_all)));

    // R10: reported V is the target's sticky bit
    a_r10_v_is_sticky: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (flag_v == sticky_all[tgt_q]));

    // R7: Z and N describe the stored target accumulator
    a_r7_zero_neg: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((flag_z == (acc_all[tgt_q*ACC_W +: ACC_W] == '0)) &&
                       (flag_n == acc_all[tgt_q*ACC_W + ACC_W - 1])));

    // R11: status write clears all sticky bits and flags
    a_r11_sr_clears: assert property (@(posedge clk) disable iff (rst)
        sr_wr |=> (sticky_all == '0 && !flag_n && !flag_z && !flag_v));

    // R11: accumulator write loads data and clears its sticky bit
    a_r11_acc_load: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> ((acc_all[wsel_q*ACC_W +: ACC_W] == $past(acc_wdata)) && !sticky_all[wsel_q]));
endmodule

bind macc_quad macc_quad_chk #(.ACC_W(ACC_W), .N_ACC(N_ACC), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_named   (op_named),
    .op_acc     (op_acc),
    .sr_wr      (sr_wr),
    .acc_wr     (acc_wr),
    .acc_wsel   (acc_wsel),
    .acc_wdata  (acc_wdata),
    .acc_all    (acc_all),
    .sticky_all (sticky_all),
    .res_valid  (res_valid),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_v     (flag_v)
);

// File: tb/macc_quad_test.sv
`timescale 1ns/1ps
module macc_quad_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 0, op_sub = 0, op_named = 0, op_word = 0, op_a_hi = 0, op_b_hi = 0;
    logic [1:0]  op_acc = 0;
    logic [31:0] op_a = 0, op_b = 0;
    logic        sr_wr = 0, sr_signed = 0, sr_frac = 0;
    logic        acc_wr = 0;
    logic [1:0]  acc_wsel = 0, acc_rsel = 0;
    logic [47:0] acc_wdata = 0;
    logic [47:0] acc_rdata;
    logic        acc_rovf, stat_signed, stat_frac, res_valid, flag_n, flag_z, flag_v;

    int total = 0;
    int fails = 0;

    localparam logic signed [71:0] P39 = 72'sd549755813888;
    localparam logic signed [71:0] P40 = 72'sd1099511627776;
    localparam logic signed [71:0] P47 = 72'sd140737488355328;
    localparam logic signed [71:0] P48 = 72'sd281474976710656;

    logic [47:0] m_acc [4];
    bit          m_stk [4];
    bit          m_n, m_z, m_v, m_signed, m_frac;

    always #2 clk = ~clk;

    macc_quad uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub), .op_named(op_named),
        .op_acc(op_acc), .op_word(op_word), .op_a_hi(op_a_hi), .op_b_hi(op_b_hi),
        .op_a(op_a), .op_b(op_b), .sr_wr(sr_wr), .sr_signed(sr_signed), .sr_frac(sr_frac),
        .acc_wr(acc_wr), .acc_wsel(acc_wsel), .acc_wdata(acc_wdata), .acc_rsel(acc_rsel),
        .acc_rdata(acc_rdata), .acc_rovf(acc_rovf), .stat_signed(stat_signed),
        .stat_frac(stat_frac), .res_valid(res_valid), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    function automatic logic signed [71:0] ext(logic [31:0] v, bit word, bit hi, bit sg);
        logic [15:0] h;
        h = hi ? v[31:16] : v[15:0];
        if (word) return sg ? {{56{h[15]}}, h} : {56'd0, h};
        return sg ? {{40{v[31]}}, v} : {40'd0, v};
    endfunction

    function automatic logic [31:0] pick(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h0000_8000;
            6: return 32'h8000_7FFF;
            7: return 32'h0001_0003;
            8: return 32'h1234_5678;
            default: return 32'hFFFE_0002;
        endcase
    endfunction

    task automatic check_accs(string tag);
        for (int i = 0; i < 4; i++) begin
            acc_rsel = 2'(i);
            #0.2;
            chk(tag, {15'd0, acc_rovf, acc_rdata}, {15'd0, m_stk[i], m_acc[i]});
        end
    endtask

    // Reference arithmetic for one accepted operation
    task automatic model_op(bit sub, bit named, logic [1:0] sel, bit word, bit ahi, bit bhi,
                            logic [31:0] a, logic [31:0] b);
        logic signed [71:0] ea, eb, p, term, ax, r;
        bit sg, povf, aovf;
        int t;
        sg   = m_frac | m_signed;
        t    = named ? int'(sel) : 0;
        ea   = ext(a, word, ahi, sg);
        eb   = ext(b, word, bhi, sg);
        p    = ea * eb;
        term = p;
        if (m_frac) begin
            term = p * 2;
            if (!word) term = term >>> 16;
        end
        povf = !word && !m_frac && (sg ? (p < -P39 || p > P39 - 1) : (p >= P40));
        ax   = sg ? {{24{m_acc[t][47]}}, m_acc[t]} : {24'd0, m_acc[t]};
        r    = sub ? ax - term : ax + term;
        aovf = sg ? (r < -P47 || r > P47 - 1) : (r < 0 || r >= P48);
        m_acc[t] = r[47:0];
        m_stk[t] = m_stk[t] | povf | aovf;
        m_v = m_stk[t];
        m_n = r[47];
        m_z = (r[47:0] == 48'd0);
    endtask

    task automatic run_op(bit sub, bit named, logic [1:0] sel, bit word, bit ahi, bit bhi,
                          logic [31:0] a, logic [31:0] b, string tag);
        @(negedge clk);
        op_valid = 1; op_sub = sub; op_named = named; op_acc = sel; op_word = word;
        op_a_hi = ahi; op_b_hi = bhi; op_a = a; op_b = b;
        model_op(sub, named, sel, word, ahi, bhi, a, b);
        @(negedge clk);
        op_valid = 0;
        chk({tag, " R13 valid"}, 64'(res_valid), 64'd1);
        chk({tag, " R7,R8,R9,R10 flags"}, {61'd0, flag_n, flag_z, flag_v}, {61'd0, m_n, m_z, m_v});
        check_accs({tag, " R2,R3,R4,R5,R6 accs"});
    endtask

    task automatic write_sr(bit s, bit f);
        @(negedge clk);
        sr_wr = 1; sr_signed = s; sr_frac = f;
        @(negedge clk);
        sr_wr = 0;
        m_signed = s; m_frac = f; m_n = 0; m_z = 0; m_v = 0;
        for (int i = 0; i < 4; i++) m_stk[i] = 0;
        chk("R11 mode", {62'd0, stat_signed, stat_frac}, {62'd0, s, f});
        chk("R11 flags cleared", {61'd0, flag_n, flag_z, flag_v}, 64'd0);
        check_accs("R11 sticky cleared");
    endtask

    task automatic write_acc(logic [1:0] sel, logic [47:0] d);
        @(negedge clk);
        acc_wr = 1; acc_wsel = sel; acc_wdata = d;
        @(negedge clk);
        acc_wr = 0;
        m_acc[sel] = d; m_stk[sel] = 0;
        check_accs("R11 acc write");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_stk[i] = 0; end
        m_n = 0; m_z = 0; m_v = 0; m_signed = 1; m_frac = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset valid", 64'(res_valid), 64'd0);
        chk("R1 reset flags", {61'd0, flag_n, flag_z, flag_v}, 64'd0);
        chk("R1 reset mode", {62'd0, stat_signed, stat_frac}, 64'd2);
        check_accs("R1 reset accs");

        // R4: long fractional -1 * -1 reaches +2^47 and overflows
        write_sr(1, 1);
        run_op(0, 1, 2'd1, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, "R4 frac long -1*-1");
        // R4: word fractional -1 * -1 = 2^31, no overflow
        run_op(0, 1, 2'd2, 1, 1, 0, 32'h8000_1234, 32'h5678_8000, "R4 frac word -1*-1");
        // R2: fractional bit alone still selects signed fractional
        write_sr(0, 1);
        run_op(1, 1, 2'd3, 1, 0, 0, 32'h0000_8000, 32'h0000_4000, "R2 frac over unsigned");
        // R8: signed long product just beyond 40 bits
        write_sr(1, 0);
        run_op(0, 1, 2'd0, 0, 0, 0, 32'h0010_0000, 32'h0008_0000, "R8 signed prod limit");
        // R6: unnamed target goes to accumulator 0 even with op_acc = 3
        run_op(1, 0, 2'd3, 0, 0, 0, 32'h0000_0005, 32'h0000_0007, "R6 unnamed target");
        // R9: unsigned subtraction below zero
        write_sr(0, 0);
        write_acc(2'd2, 48'd3);
        run_op(1, 1, 2'd2, 0, 0, 0, 32'd2, 32'd2, "R9 unsigned underflow");
        // R10: sticky survives a clean operation
        run_op(0, 1, 2'd2, 0, 0, 0, 32'd0, 32'd0, "R10 sticky persists");

        // R12: operation dropped when colliding with a write
        @(negedge clk);
        op_valid = 1; op_named = 1; op_acc = 2'd1; op_word = 0; op_a = 32'd9; op_b = 32'd9;
        acc_wr = 1; acc_wsel = 2'd1; acc_wdata = 48'h0000_0000_00AA;
        @(negedge clk);
        op_valid = 0; acc_wr = 0;
        m_acc[1] = 48'h0000_0000_00AA; m_stk[1] = 0;
        chk("R12 dropped op no valid", 64'(res_valid), 64'd0);
        check_accs("R12 dropped op accs");
        @(negedge clk);
        op_valid = 1; op_acc = 2'd1; sr_wr = 1; sr_signed = 1; sr_frac = 0;
        @(negedge clk);
        op_valid = 0; sr_wr = 0;
        m_signed = 1; m_frac = 0; m_n = 0; m_z = 0; m_v = 0;
        for (int i = 0; i < 4; i++) m_stk[i] = 0;
        chk("R12 dropped with sr write", 64'(res_valid), 64'd0);
        chk("R12 flags", {61'd0, flag_n, flag_z, flag_v}, 64'd0);
        check_accs("R12 accs after sr write");
        @(negedge clk);
        chk("R13 strobe idle", 64'(res_valid), 64'd0);

        // Sweep of corner operands across formats, sizes and directions
        cnt = 0;
        for (int md = 0; md < 3; md++) begin
            write_sr(md != 0, md == 2);
            for (int w = 0; w < 2; w++) begin
                for (int ia = 0; ia < 10; ia++) begin
                    for (int ib = 0; ib < 10; ib++) begin
                        if (cnt % 16 == 0) begin
                            case ((cnt / 16) % 4)
                                0: write_acc(2'(cnt), 48'h7FFF_FFFF_F000);
                                1: write_acc(2'(cnt), 48'h8000_0000_1000);
                                2: write_acc(2'(cnt), 48'h0);
                                default: write_acc(2'(cnt), 48'hFFFF_FFFF_FFFF);
                            endcase
                        end
                        run_op(((ia + ib) % 2) == 1, (cnt % 5) != 0, 2'(cnt / 3), w == 1,
                               (ia % 2) == 1, ((ib / 2) % 2) == 1, pick(ia), pick(ib), "sweep");
                        cnt++;
                    end
                end
            end
        end

        summary();
        $finish;
    end
endmodule